// File: doc/BRIEF.md
# Bonded Word Sync Sequence Generator

This block sits on the transmit side of a multi-lane serial link, one lane per 8B/10B character stream. In normal operation each lane forwards a pre-encoded 10-bit code group from its input to a registered output and keeps track of the running disparity of what it has sent. When a lane sees its sync request high on a character clock edge, it replaces its stream with a fixed run of sixteen K28.5 comma characters. The positive or negative form of each comma is dictated by a fixed pattern rather than by the running disparity, so a receiver can recover character and word alignment from it.

Lanes can run alone, be bonded in adjacent pairs, or be bonded in groups of four. In a bonded group a single request on the group's lowest lane starts the sequence on every lane of the group in the same cycle. An atomic control selects whether a sequence in flight may be restarted by a new request or must run to its end. While a sequence is being sent, the characters offered at the input are discarded, and pass-through resumes on the very next character once the sixteenth comma is out.

Top module: `wss_gen`

## Requirements
- R1: While reset is high and in the cycle after it falls, every lane outputs code group 0 with busy low, and the lane's running disparity is negative.
- R2: With busy low and no effective sync request, a lane's input code group appears on its output one clock edge later, and busy stays low.
- R3: Every output code group updates the lane's running disparity: six ones make it positive, four ones make it negative, any other count leaves it unchanged.
- R4: An accepted request makes the next output the first of sixteen commas. Writing P for 0011111010 and N for 1100000101, with negative disparity at the start the order is P P N N followed by P N repeated six times; with positive disparity every character is the opposite form.
- R5: Busy is high while the first fifteen commas are on the output and low while the sixteenth is; the input sampled on the accepting edge and on the fifteen edges after it is dropped.
- R6: With atomic high, a request sampled while busy is high is ignored and the sequence continues unchanged.
- R7: With atomic low, a request sampled while busy is high restarts the sequence at its first character, choosing the form from the current disparity.
- R8: Bond mode 00 (independent): each lane is started only by its own request bit.
- R9: Bond mode 01 (pairs): lanes 0 and 1 are started by request bit 0, lanes 2 and 3 by request bit 2; request bits 1 and 3 have no effect.
- R10: Bond mode 1x (quad): request bit 0 starts lanes 0 to 3 together; the other request bits have no effect.
- R11: A request sampled while the sixteenth comma is on the output is accepted, giving back-to-back sequences that start from the disparity left by the last comma.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| bond_mode | input | 2 | 00 independent, 01 pairs, 1x quad |
| atomic | input | 1 | High: sequences cannot be restarted |
| tx_cg | input | 40 | Pre-encoded code groups, lane n in bits 10n+9:10n |
| tx_sync | input | 4 | Per-lane sync request, sampled on the clock edge |
| cg_o | output | 40 | Registered output code groups, same lane packing |
| busy_o | output | 4 | Per-lane sequence in progress, input being dropped |

## Verification
Two functions can meet in one cycle: a new sync request and a sequence already in flight on the same lane, either in its middle or on its last character. The stimulus raises requests at random on every lane and mode, including bonded groups where one lane's request lands on another lane that is mid-sequence, and holds requests high for long stretches to hit the final-character case. A bench model decides, per lane and per edge, whether the request is ignored, restarts the run or chains a fresh run, and the outputs and busy flags of all four lanes are compared to it every cycle.

// File: rtl/wss_pkg.sv
`timescale 1ns/1ps
package wss_pkg;
  localparam int CG_W = 10;
  localparam logic [CG_W-1:0] K_POS = 10'b0011111010;
  localparam logic [CG_W-1:0] K_NEG = 10'b1100000101;

  // forced form of character i of the sequence, for a negative starting disparity
  function automatic logic pat_plus(input int unsigned i);
    return (i < 2) || ((i >= 4) && (i % 2 == 0));
  endfunction

  // running disparity after sending cg
  function automatic logic rd_after(input logic rd, input logic [CG_W-1:0] cg);
    int n;
    n = $countones(cg);
    if (n == 6) return 1'b1;
    if (n == 4) return 1'b0;
    return rd;
  endfunction
endpackage

// File: rtl/wss_router.sv
`timescale 1ns/1ps
module wss_router #(
  parameter int NLANES = 4
) (
  input  logic [1:0]        bond_mode,
  input  logic [NLANES-1:0] sync_in,
  output logic [NLANES-1:0] go
);
  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    localparam int PAIR_SRC = (i / 2) * 2;
    localparam int QUAD_SRC = (i / 4) * 4;
    always_comb begin
      if (bond_mode[1])      go[i] = sync_in[QUAD_SRC];
      else if (bond_mode[0]) go[i] = sync_in[PAIR_SRC];
      else                   go[i] = sync_in[i];
    end
  end
endmodule

// File: rtl/wss_lane.sv
`timescale 1ns/1ps
module wss_lane
  import wss_pkg::*;
#(
  parameter int SEQ_LEN = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            atomic,
  input  logic            go,
  input  logic [CG_W-1:0] tx_cg,
  output logic [CG_W-1:0] cg_o,
  output logic            busy_o
);
  localparam int IW = $clog2(SEQ_LEN);
  localparam logic [IW-1:0] LAST = IW'(SEQ_LEN - 1);

  logic [CG_W-1:0] cg_q, nxt_cg;
  logic [IW-1:0]   idx_q, nxt_idx;
  logic            busy_q, nxt_busy;
  logic            inv_q, nxt_inv;
  logic            rd_q;
  logic            accept;

  assign accept = go && (!busy_q || !atomic);

  always_comb begin
    nxt_cg   = tx_cg;
    nxt_idx  = idx_q;
    nxt_inv  = inv_q;
    nxt_busy = 1'b0;
    if (accept) begin
      nxt_inv  = rd_q;
      nxt_idx  = '0;
      nxt_cg   = (pat_plus(0) ^ rd_q) ? K_POS : K_NEG;
      nxt_busy = 1'b1;
    end else if (busy_q) begin
      nxt_idx  = idx_q + 1'b1;
      nxt_cg   = (pat_plus(int'(nxt_idx)) ^ inv_q) ? K_POS : K_NEG;
      nxt_busy = (nxt_idx != LAST);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cg_q   <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      inv_q  <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      cg_q   <= nxt_cg;
      idx_q  <= nxt_idx;
      busy_q <= nxt_busy;
      inv_q  <= nxt_inv;
      rd_q   <= rd_after(rd_q, nxt_cg);
    end
  end

  assign cg_o   = cg_q;
  assign busy_o = busy_q;

  p_busy_comma_r4: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cg_q == K_POS || cg_q == K_NEG));

  p_first_form_r4: assert property (@(posedge clk) disable iff (rst)
    (go && !busy_q) |=> (cg_q == ($past(rd_q) ? K_NEG : K_POS)));

  p_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !go) |=> (cg_q == $past(tx_cg) && !busy_q));

  p_rd_pos_r3: assert property (@(posedge clk) disable iff (rst)
    ($countones(cg_q) == 6) |-> rd_q);

  p_rd_neg_r3: assert property (@(posedge clk) disable iff (rst)
    ($countones(cg_q) == 4) |-> !rd_q);

  p_atomic_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (atomic && busy_q) |=> (idx_q == $past(idx_q) + 1'b1));

  p_end_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && idx_q == LAST - 1'b1 && !(go && !atomic)) |=> !busy_q);
endmodule

// File: rtl/wss_gen.sv
`timescale 1ns/1ps
module wss_gen
  import wss_pkg::*;
#(
  parameter int NLANES  = 4,
  parameter int SEQ_LEN = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             bond_mode,
  input  logic                   atomic,
  input  logic [NLANES*CG_W-1:0] tx_cg,
  input  logic [NLANES-1:0]      tx_sync,
  output logic [NLANES*CG_W-1:0] cg_o,
  output logic [NLANES-1:0]      busy_o
);
  logic [NLANES-1:0] go;

  wss_router #(.NLANES(NLANES)) u_router (
    .bond_mode (bond_mode),
    .sync_in   (tx_sync),
    .go        (go)
  );

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    wss_lane #(.SEQ_LEN(SEQ_LEN)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .atomic (atomic),
      .go     (go[i]),
      .tx_cg  (tx_cg[i*CG_W +: CG_W]),
      .cg_o   (cg_o[i*CG_W +: CG_W]),
      .busy_o (busy_o[i])
    );
  end

  if (NLANES >= 2) begin : g_pair_chk
    // R9: in pair mode a request on lane 1 alone never starts lane 1 from idle
    p_pair_ignore_r9: assert property (@(posedge clk) disable iff (rst)
      (bond_mode == 2'b01 && tx_sync[1] && !tx_sync[0] && !busy_o[1]) |=> !busy_o[1]);
  end
endmodule

// File: tb/wss_gen_tb.sv
`timescale 1ns/1ps
module wss_gen_tb;
  localparam int NL = 4;
  localparam logic [9:0] KP = 10'b0011111010;
  localparam logic [9:0] KN = 10'b1100000101;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    bond_mode = 2'b00;
  logic          atomic = 1'b1;
  logic [NL*10-1:0] tx_cg = '0;
  logic [NL-1:0] tx_sync = '0;
  logic [NL*10-1:0] cg_o;
  logic [NL-1:0] busy_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  string tag = "R1";

  logic       m_rd[NL];
  logic       m_busy[NL];
  logic       m_inv[NL];
  int         m_idx[NL];
  logic [9:0] m_cg[NL];

  always #4 clk = ~clk;

  wss_gen #(.NLANES(NL), .SEQ_LEN(16)) u_dut (
    .clk(clk), .rst(rst), .bond_mode(bond_mode), .atomic(atomic),
    .tx_cg(tx_cg), .tx_sync(tx_sync), .cg_o(cg_o), .busy_o(busy_o)
  );

  function automatic bit want_pos(int i);
    return (i == 0 || i == 1) || (i > 3 && (i % 2) == 0);
  endfunction

  function automatic int src_lane(int l, logic [1:0] bm);
    if (bm[1]) return (l / 4) * 4;
    if (bm[0]) return (l / 2) * 2;
    return l;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_step();
    for (int l = 0; l < NL; l++) begin
      bit g;
      int ones;
      g = tx_sync[src_lane(l, bond_mode)];
      if (g && (!m_busy[l] || !atomic)) begin
        m_inv[l] = m_rd[l];
        m_idx[l] = 0;
        m_cg[l]  = (want_pos(0) != m_rd[l]) ? KP : KN;
        m_busy[l] = 1;
      end else if (m_busy[l]) begin
        m_idx[l]++;
        m_cg[l]  = (want_pos(m_idx[l]) != m_inv[l]) ? KP : KN;
        m_busy[l] = (m_idx[l] != 15);
      end else begin
        m_cg[l] = tx_cg[l*10 +: 10];
        m_busy[l] = 0;
      end
      ones = $countones(m_cg[l]);
      if (ones == 6) m_rd[l] = 1;
      else if (ones == 4) m_rd[l] = 0;
    end
  endtask

  task automatic compare_all();
    for (int l = 0; l < NL; l++) begin
      chk({tag, " cg"}, 32'(cg_o[l*10 +: 10]), 32'(m_cg[l]));
      chk({tag, " busy"}, 32'(busy_o[l]), 32'(m_busy[l]));
    end
  endtask

  // inputs are driven before this call at a falling edge
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic rand_phase(string t, logic [1:0] bm, logic at, int n, int pct);
    tag = t;
    bond_mode = bm;
    atomic = at;
    for (int c = 0; c < n; c++) begin
      for (int l = 0; l < NL; l++) begin
        tx_cg[l*10 +: 10] = 10'($urandom);
        tx_sync[l] = ($urandom_range(99) < pct);
      end
      cyc();
    end
    tx_sync = '0;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int l = 0; l < NL; l++) begin
      m_rd[l] = 0; m_busy[l] = 0; m_inv[l] = 0; m_idx[l] = 0; m_cg[l] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset cg", 32'(cg_o), 32'(0));
    chk("R1 reset busy", 32'(busy_o), 32'(0));
    rst = 1'b0;
    tx_cg = '0;
    cyc();
    chk("R1 after reset cg", 32'(cg_o), 32'(0));

    // R4: directed sequence from negative disparity on lane 0
    tag = "R4";
    tx_cg[9:0] = 10'b1010101010;
    tx_sync = 4'b0001;
    cyc();
    tx_sync = '0;
    chk("R4 first char neg rd", 32'(cg_o[9:0]), 32'(KP));
    chk("R5 busy on first char", 32'(busy_o[0]), 32'(1));
    for (int i = 1; i < 16; i++) begin
      tx_cg[9:0] = 10'($urandom);
      cyc();
      chk("R4 pattern", 32'(cg_o[9:0]), 32'(want_pos(i) ? KP : KN));
      chk("R5 busy window", 32'(busy_o[0]), 32'(i != 15));
    end
    tx_cg[9:0] = 10'b0000111111;
    cyc();
    chk("R5 no idle after sequence", 32'(cg_o[9:0]), 32'(10'b0000111111));
    // lane 0 disparity is now positive: complement pattern
    tx_cg[9:0] = 10'b1010101010;
    tx_sync = 4'b0001;
    cyc();
    tx_sync = '0;
    chk("R4 first char pos rd", 32'(cg_o[9:0]), 32'(KN));
    for (int i = 1; i < 16; i++) begin
      cyc();
      chk("R4 complement pattern", 32'(cg_o[9:0]), 32'(want_pos(i) ? KN : KP));
    end

    // R11: requests held high give back-to-back runs
    tag = "R11";
    tx_sync = 4'b0001;
    for (int c = 0; c < 40; c++) cyc();
    tx_sync = '0;
    for (int c = 0; c < 20; c++) cyc();

    rand_phase("R2 R3 R5 R8", 2'b00, 1'b1, 400, 6);
    rand_phase("R6 R9", 2'b01, 1'b1, 400, 10);
    rand_phase("R7 R10", 2'b10, 1'b0, 400, 8);
    rand_phase("R6 R10", 2'b11, 1'b1, 300, 10);
    rand_phase("R7 R8", 2'b00, 1'b0, 300, 8);
    rand_phase("R7 R9", 2'b01, 1'b0, 300, 8);
    rand_phase("R11 R6", 2'b00, 1'b1, 200, 60);
    rand_phase("R2 R3", 2'b00, 1'b1, 100, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule